// File: doc/BRIEF.md
# SDRAM Read Latency and Mask Pipeline

This block sits in the controller half of an 8-bit synchronous DRAM data path. It follows every read burst from the clock it is issued until its last beat crosses the data bus, and it tells the capture logic which clock holds a beat, which beat it is, and whether that beat was blanked by the mask. It also drives the data-mask pin. For a read beat, the mask is raised two clocks before the beat is due. For a write beat, it is raised on the same clock as the beat.

Scheduled beats live in a shift register whose slot index is the number of clocks until the beat reaches the bus. A burst stop, a precharge or a new read clears every slot at or beyond the read latency, so beats that have not yet reached the bus are dropped. A new read then fills its own beats into the same slots. The read latency is a programmed value of two or three clocks. A new value is accepted only while no beat is scheduled.

Top module: `rd_lat_pipe`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `dqm`=1, `rd_valid`=0, `rd_masked`=0, `bus_idle`=1 and `lat_err`=0. The read latency returns to 3 clocks.
- R2: Let `rd_issue` be high at edge n, with latency L and `bl_code` c. Beat k is presented after edge n+L+k for each k below 2^c, so codes 0,1,2,3 give 1,2,4,8 beats. An unmasked beat raises `rd_valid`, and `rd_idx` shows k.
- R3: Beat k of a read takes its mask from `rd_mask[k]` (bit k, 1 = blank). That value is driven on `dqm` after edge n+L+k-2. A blanked beat raises `rd_masked` instead of `rd_valid`.
- R4: When `wr_beat` is high at an edge, `dqm` after that edge equals `wr_mask`. This holds even if a read beat also needs the mask on that edge.
- R5: After any edge at which neither a write beat nor a read beat due two clocks later needs the mask, `dqm` is 1.
- R6: A `rd_stop` pulse at edge s drops every beat due at edge s+L or later. Beats due earlier are still presented.
- R7: A `rd_pre` pulse at edge s drops beats under the same rule as R6.
- R8: A `rd_issue` at edge n first drops the beats of any earlier burst that are due at edge n+L or later, then schedules its own beats.
- R9: A `lat_load` pulse at an edge with no beat scheduled and no `rd_issue` sets the latency used from the next edge on. `lat_sel`=0 selects 2 clocks and `lat_sel`=1 selects 3 clocks.
- R10: A `lat_load` pulse while a beat is scheduled, or together with `rd_issue`, leaves the latency unchanged and raises `lat_err` for one clock after that edge.
- R11: `bus_idle` after an edge is 1 exactly when no beat is presented at that edge and no beat is scheduled for a later edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_issue | input | 1 | Read command issued this edge |
| bl_code | input | 2 | Burst length code, beats = 2^code |
| rd_mask | input | 8 | Per-beat blanking request for the read, bit k for beat k |
| rd_stop | input | 1 | Burst stop command this edge |
| rd_pre | input | 1 | Precharge command this edge |
| wr_beat | input | 1 | A write data beat goes out this edge |
| wr_mask | input | 1 | Mask for that write beat |
| lat_load | input | 1 | Request to change the read latency |
| lat_sel | input | 1 | Latency choice: 0 = 2 clocks, 1 = 3 clocks |
| dqm | output | 1 | Data-mask pin |
| rd_valid | output | 1 | Unmasked read beat on the bus this clock |
| rd_masked | output | 1 | Blanked read beat slot this clock |
| rd_idx | output | 3 | Index of the beat in its burst |
| bus_idle | output | 1 | No beat present or scheduled |
| lat_err | output | 1 | Latency change rejected |

## Verification
The hardest case to reach is a truncation whose boundary falls inside the two-clock mask lead. A stop, precharge or new read can drop a beat whose mask value has already been driven, while a mask value still to be driven must fall back to 1. The stimulus sends eight-beat bursts at both latencies and hits them with a stop, a precharge and a second read placed a few clocks after the issue, which lands the cut between beats that are already committed. A latency change is also requested in the middle of a burst and on the same clock as a read, to show the rejection and that the next read still uses the old latency.

// File: rtl/rlp_pkg.sv
package rlp_pkg;
  typedef enum logic {
    LAT_SHORT = 1'b0,
    LAT_LONG  = 1'b1
  } lat_choice_e;

  // Beats in a burst: 2^code, capped at the pipeline's maximum burst.
  function automatic int beats_of(input logic [7:0] code, input int cap);
    int b;
    b = (code > 8'd15) ? cap : (1 << code);
    return (b > cap) ? cap : b;
  endfunction
endpackage

// File: rtl/rlp_lat_ctrl.sv
module rlp_lat_ctrl #(
  parameter int LAT_LO   = 2,
  parameter int LAT_HI   = 3,
  parameter int RST_LAT  = 3,
  parameter int CL_W     = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lat_load,
  input  logic            lat_sel,
  input  logic            busy,
  output logic [CL_W-1:0] cl,
  output logic            lat_err
);
  import rlp_pkg::*;

  lat_choice_e choice;
  assign choice = lat_choice_e'(lat_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      cl      <= CL_W'(RST_LAT);
      lat_err <= 1'b0;
    end else begin
      lat_err <= lat_load & busy;
      if (lat_load && !busy)
        cl <= (choice == LAT_LONG) ? CL_W'(LAT_HI) : CL_W'(LAT_LO);
    end
  end
endmodule

// File: rtl/rlp_sched.sv
module rlp_sched #(
  parameter int MAX_BL = 8,
  parameter int DEPTH  = 11,
  parameter int IDX_W  = 3,
  parameter int CL_W   = 2,
  parameter int BLC_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_issue,
  input  logic [BLC_W-1:0]  bl_code,
  input  logic [MAX_BL-1:0] rd_mask,
  input  logic              cut,
  input  logic [CL_W-1:0]   cl,
  output logic              cur_live,
  output logic              cur_msk,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              lead_live,
  output logic              lead_msk,
  output logic              any_live,
  output logic              next_any
);
  import rlp_pkg::*;

  // Slot j holds the beat presented j+1 edges from now.
  logic [DEPTH-1:0] live_q, msk_q, live_d, msk_d;
  logic [IDX_W-1:0] idx_q [DEPTH];
  logic [IDX_W-1:0] idx_d [DEPTH];

  always_comb begin
    int blen;
    int kk;
    blen = beats_of(8'(bl_code), MAX_BL);
    live_d = {1'b0, live_q[DEPTH-1:1]};
    msk_d  = {1'b0, msk_q[DEPTH-1:1]};
    for (int j = 0; j < DEPTH - 1; j++) idx_d[j] = idx_q[j+1];
    idx_d[DEPTH-1] = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if ((rd_issue || cut) && (j + 1 >= int'(cl))) live_d[j] = 1'b0;
      kk = j + 1 - int'(cl);
      if (rd_issue && kk >= 0 && kk < blen) begin
        live_d[j] = 1'b1;
        msk_d[j]  = rd_mask[kk[IDX_W-1:0]];
        idx_d[j]  = kk[IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      msk_q  <= '0;
      for (int j = 0; j < DEPTH; j++) idx_q[j] <= '0;
    end else begin
      live_q <= live_d;
      msk_q  <= msk_d;
      for (int j = 0; j < DEPTH; j++) idx_q[j] <= idx_d[j];
    end
  end

  assign cur_live  = live_q[0];
  assign cur_msk   = msk_q[0];
  assign cur_idx   = idx_q[0];
  assign lead_live = live_d[1];
  assign lead_msk  = msk_d[1];
  assign any_live  = |live_q;
  assign next_any  = |live_d;
endmodule

// File: rtl/rlp_out.sv
module rlp_out #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cur_live,
  input  logic             cur_msk,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic             lead_live,
  input  logic             lead_msk,
  input  logic             next_any,
  input  logic             wr_beat,
  input  logic             wr_mask,
  output logic             dqm,
  output logic             rd_valid,
  output logic             rd_masked,
  output logic [IDX_W-1:0] rd_idx,
  output logic             bus_idle
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dqm       <= 1'b1;
      rd_valid  <= 1'b0;
      rd_masked <= 1'b0;
      rd_idx    <= '0;
      bus_idle  <= 1'b1;
    end else begin
      // Write mask acts at once; read mask leads its beat by two clocks.
      if (wr_beat)        dqm <= wr_mask;
      else if (lead_live) dqm <= lead_msk;
      else                dqm <= 1'b1;
      rd_valid  <= cur_live & ~cur_msk;
      rd_masked <= cur_live & cur_msk;
      rd_idx    <= cur_live ? cur_idx : '0;
      bus_idle  <= ~(cur_live | next_any);
    end
  end
endmodule

// File: rtl/rd_lat_pipe.sv
module rd_lat_pipe #(
  parameter int MAX_BL  = 8,
  parameter int LAT_LO  = 2,
  parameter int LAT_HI  = 3,
  parameter int RST_LAT = 3,
  parameter int BLC_W   = 2,
  parameter int IDX_W   = $clog2(MAX_BL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_issue,
  input  logic [BLC_W-1:0]  bl_code,
  input  logic [MAX_BL-1:0] rd_mask,
  input  logic              rd_stop,
  input  logic              rd_pre,
  input  logic              wr_beat,
  input  logic              wr_mask,
  input  logic              lat_load,
  input  logic              lat_sel,
  output logic              dqm,
  output logic              rd_valid,
  output logic              rd_masked,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              bus_idle,
  output logic              lat_err
);
  localparam int DEPTH = LAT_HI + MAX_BL;
  localparam int CL_W  = $clog2(LAT_HI + 1);

  logic [CL_W-1:0]  cl;
  logic             cur_live, cur_msk, lead_live, lead_msk, any_live, next_any;
  logic [IDX_W-1:0] cur_idx;
  logic             busy;

  assign busy = any_live | rd_issue;

  rlp_lat_ctrl #(
    .LAT_LO(LAT_LO), .LAT_HI(LAT_HI), .RST_LAT(RST_LAT), .CL_W(CL_W)
  ) u_lat (
    .clk(clk), .rst(rst), .lat_load(lat_load), .lat_sel(lat_sel),
    .busy(busy), .cl(cl), .lat_err(lat_err)
  );

  rlp_sched #(
    .MAX_BL(MAX_BL), .DEPTH(DEPTH), .IDX_W(IDX_W), .CL_W(CL_W), .BLC_W(BLC_W)
  ) u_sched (
    .clk(clk), .rst(rst), .rd_issue(rd_issue), .bl_code(bl_code),
    .rd_mask(rd_mask), .cut(rd_stop | rd_pre), .cl(cl),
    .cur_live(cur_live), .cur_msk(cur_msk), .cur_idx(cur_idx),
    .lead_live(lead_live), .lead_msk(lead_msk),
    .any_live(any_live), .next_any(next_any)
  );

  rlp_out #(.IDX_W(IDX_W)) u_out (
    .clk(clk), .rst(rst), .cur_live(cur_live), .cur_msk(cur_msk),
    .cur_idx(cur_idx), .lead_live(lead_live), .lead_msk(lead_msk),
    .next_any(next_any), .wr_beat(wr_beat), .wr_mask(wr_mask),
    .dqm(dqm), .rd_valid(rd_valid), .rd_masked(rd_masked),
    .rd_idx(rd_idx), .bus_idle(bus_idle)
  );
endmodule

// File: rtl/rd_lat_pipe_chk.sv
module rd_lat_pipe_chk #(
  parameter int CL_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            rd_issue,
  input logic            wr_beat,
  input logic            wr_mask,
  input logic            lat_load,
  input logic            dqm,
  input logic            rd_valid,
  input logic            rd_masked,
  input logic            bus_idle,
  input logic            lat_err,
  input logic [CL_W-1:0] cl
);
  logic rst_d = 1'b0;

  always @(posedge clk) begin
    if (rst_d) begin
      p_reset_state_r1: assert (dqm && !rd_valid && !rd_masked && bus_idle && !lat_err)
        else $error("reset state wrong");
    end
    rst_d <= rst;
  end

  p_valid_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && rd_masked));

  p_wr_dqm_r4: assert property (@(posedge clk) disable iff (rst)
    wr_beat |=> (dqm == $past(wr_mask)));

  p_err_with_read_r10: assert property (@(posedge clk) disable iff (rst)
    (lat_load && rd_issue) |=> lat_err);

  p_lat_hold_r10: assert property (@(posedge clk) disable iff (rst)
    lat_err |-> (cl == $past(cl)));

  p_idle_no_beat_r11: assert property (@(posedge clk) disable iff (rst)
    bus_idle |-> (!rd_valid && !rd_masked));

  p_idle_next_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    bus_idle |=> (!rd_valid && !rd_masked));
endmodule

bind rd_lat_pipe rd_lat_pipe_chk #(.CL_W(CL_W)) u_chk (
  .clk(clk), .rst(rst), .rd_issue(rd_issue), .wr_beat(wr_beat),
  .wr_mask(wr_mask), .lat_load(lat_load), .dqm(dqm), .rd_valid(rd_valid),
  .rd_masked(rd_masked), .bus_idle(bus_idle), .lat_err(lat_err), .cl(cl)
);

// File: tb/rd_lat_pipe_bench.sv
module rd_lat_pipe_bench;
  localparam int MAXE = 1024;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_issue = 0, rd_stop = 0, rd_pre = 0, wr_beat = 0, wr_mask = 0;
  logic       lat_load = 0, lat_sel = 0;
  logic [1:0] bl_code = 0;
  logic [7:0] rd_mask = 0;
  logic       dqm, rd_valid, rd_masked, bus_idle, lat_err;
  logic [2:0] rd_idx;

  rd_lat_pipe u_rd_lat_pipe (
    .clk(clk), .rst(rst), .rd_issue(rd_issue), .bl_code(bl_code),
    .rd_mask(rd_mask), .rd_stop(rd_stop), .rd_pre(rd_pre),
    .wr_beat(wr_beat), .wr_mask(wr_mask), .lat_load(lat_load),
    .lat_sel(lat_sel), .dqm(dqm), .rd_valid(rd_valid),
    .rd_masked(rd_masked), .rd_idx(rd_idx), .bus_idle(bus_idle),
    .lat_err(lat_err)
  );

  always #5 clk = ~clk;

  // Expected timeline, indexed by edge number.
  bit       live [MAXE];
  bit       msk  [MAXE];
  int       idx  [MAXE];
  bit       edqm [MAXE];
  bit       eerr [MAXE];
  int       ecnt = 0;
  int       cl_m = 3;
  int       nchk = 0, nfail = 0;
  bit       done = 0;
  string    tag = "R1";

  always @(posedge clk) ecnt <= ecnt + 1;

  initial begin
    for (int i = 0; i < MAXE; i++) begin
      live[i] = 0; msk[i] = 0; idx[i] = 0; edqm[i] = 1; eerr[i] = 0;
    end
  end

  task automatic cmp(input string fld, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s edge %0d: actual %0d expected %0d", tag, fld, ecnt, act, exp);
    end
  endtask

  // Monitor: compare outputs shortly after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!done && ecnt < MAXE - 20) begin
        bit any;
        any = 0;
        for (int b = ecnt; b < ecnt + 16; b++) if (live[b]) any = 1;
        cmp("rd_valid(R2)", int'(rd_valid), int'(live[ecnt] && !msk[ecnt]));
        cmp("rd_masked(R3)", int'(rd_masked), int'(live[ecnt] && msk[ecnt]));
        if (live[ecnt]) cmp("rd_idx(R2)", int'(rd_idx), idx[ecnt]);
        cmp("dqm(R3,R4,R5)", int'(dqm), int'(edqm[ecnt]));
        cmp("lat_err(R10)", int'(lat_err), int'(eerr[ecnt]));
        cmp("bus_idle(R11)", int'(bus_idle), int'(!any));
      end
    end
  end

  // Driver: set inputs for the next edge and record what it must produce.
  task automatic drive(input bit iss, input logic [1:0] code, input logic [7:0] m,
                       input bit stp, input bit pre, input bit wr, input bit wm,
                       input bit ld, input bit sel);
    int n;
    bit busy;
    @(negedge clk);
    rd_issue = iss; bl_code = code; rd_mask = m; rd_stop = stp; rd_pre = pre;
    wr_beat = wr; wr_mask = wm; lat_load = ld; lat_sel = sel;
    n = ecnt + 1;
    busy = iss;
    for (int b = n; b < n + 16; b++) if (live[b]) busy = 1;
    if (iss || stp || pre) begin
      for (int b = n + cl_m; b < n + cl_m + 16; b++) begin
        if (live[b]) begin
          live[b] = 0;
          if (b - 2 >= n) edqm[b-2] = 1;
        end
      end
    end
    if (iss) begin
      for (int k = 0; k < (1 << code); k++) begin
        live[n+cl_m+k] = 1;
        msk[n+cl_m+k]  = m[k];
        idx[n+cl_m+k]  = k;
        edqm[n+cl_m+k-2] = m[k];
      end
    end
    if (wr) edqm[n] = wm;
    if (ld) begin
      if (busy) eerr[n] = 1;
      else cl_m = sel ? 3 : 2;
    end
  endtask

  task automatic quiet(input int k);
    for (int i = 0; i < k; i++) drive(0, 2'd0, 8'h00, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(input logic [1:0] code, input logic [7:0] m);
    drive(1, code, m, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    // R1: reset state is checked on the edges while rst is high
    tag = "R1";
    repeat (3) @(negedge clk);
    rst = 0;
    tag = "R5";
    quiet(5);
    // R1 default latency 3, R2 basic burst of four
    tag = "R2";
    rd(2'd2, 8'h00);
    quiet(10);
    // R9: latency change while idle, then masked burst of eight (R3)
    tag = "R9";
    drive(0, 2'd0, 8'h00, 0, 0, 0, 0, 1, 0);
    quiet(2);
    tag = "R3";
    rd(2'd3, 8'b1010_0110);
    quiet(12);
    tag = "R2";
    rd(2'd0, 8'h00);
    quiet(4);
    rd(2'd1, 8'h01);
    quiet(5);
    // R6: burst stop three clocks after issue, latency 2
    tag = "R6";
    rd(2'd3, 8'h00);
    quiet(3);
    drive(0, 2'd0, 8'h00, 1, 0, 0, 0, 0, 0);
    quiet(10);
    // R10: change latency mid burst, and together with a read
    tag = "R10";
    rd(2'd3, 8'h00);
    quiet(1);
    drive(0, 2'd0, 8'h00, 0, 0, 0, 0, 1, 1);
    quiet(12);
    drive(1, 2'd1, 8'h00, 0, 0, 0, 0, 1, 1);
    quiet(6);
    tag = "R9";
    drive(0, 2'd0, 8'h00, 0, 0, 0, 0, 1, 1);
    quiet(2);
    // R7: precharge two clocks after issue, latency 3
    tag = "R7";
    rd(2'd3, 8'h10);
    quiet(2);
    drive(0, 2'd0, 8'h00, 0, 1, 0, 0, 0, 0);
    quiet(10);
    // R8: second read cuts the first one
    tag = "R8";
    rd(2'd3, 8'h00);
    quiet(2);
    rd(2'd2, 8'h05);
    quiet(10);
    for (int i = 0; i < 4; i++) rd(2'd0, 8'(i[0]));
    quiet(8);
    // R4: write masks, and a write over a pending read mask
    tag = "R4";
    drive(0, 2'd0, 8'h00, 0, 0, 1, 0, 0, 0);
    drive(0, 2'd0, 8'h00, 0, 0, 1, 1, 0, 0);
    drive(0, 2'd0, 8'h00, 0, 0, 1, 0, 0, 0);
    drive(0, 2'd0, 8'h00, 0, 0, 1, 1, 0, 0);
    quiet(2);
    rd(2'd2, 8'h00);
    drive(0, 2'd0, 8'h00, 0, 0, 1, 1, 0, 0);
    quiet(10);
    // R6 with latency 3: stop on the same edge as a new read
    tag = "R6";
    rd(2'd3, 8'h00);
    quiet(1);
    drive(1, 2'd1, 8'h02, 1, 0, 0, 0, 0, 0);
    quiet(12);
    done = 1;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule